// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one storage cell of an inter-thread synchronisation unit, set up as a counting semaphore. It holds one counter word and a small tag. Requesters reach it through a single access port. Each access carries a view code, taken from address bits [6:3], and that code selects how the access is read. A load in the semaphore views performs a "wait": it returns the count and takes one from it. A store in the semaphore views performs a "signal": it adds one to the count and releases every thread that is waiting.

A wait in the blocking view on an empty count does not complete. The cell raises a stall response for that request and marks the requesting thread in a bitmap of blocked threads. The next signal drives a wake pulse and the wake mask in the same cycle, and the bitmap clears on the following clock edge. The surrounding fabric decides how the marked threads are held and retried. The raw counter is also visible through a pass-through view, and the tag through a control view. A cell built with its FIFO flag set ignores every semaphore access.

The access port is combinational. The response is valid in the cycle of the request, and state changes at the next rising clock edge.

Top module: `semCountCell`

## Requirements
- R1: The view code is reqAddr[6:3]. Code 0 is pass-through, 1 is control, 4 is blocking semaphore and 5 is non-blocking semaphore. A read with any other code returns all ones, and a write with any other code changes nothing.
- R2: A semaphore read (code 4 or 5) of a count greater than zero returns the count as it stood before the access and lowers it by one. It does not stall.
- R3: A blocking semaphore read (code 4) of a zero count asserts rspStall, returns zero, leaves the count at zero and sets bit reqThread of blockedMap.
- R4: A non-blocking semaphore read (code 5) of a zero count returns zero without stalling, and leaves the count and blockedMap unchanged.
- R5: A semaphore write (code 4 or 5) ignores reqData and raises the count by one. The count saturates at 2^COUNT_W-1, which is 0xFFFF by default.
- R6: During a semaphore write, wakePulse is high in that same cycle if and only if blockedMap is non-zero, and wakeMask equals blockedMap. blockedMap reads zero after that clock edge.
- R7: In a cell whose FIFO flag is set (parameter FIFO_FLAG_INIT=1), semaphore reads return zero without stalling, and semaphore accesses change neither the count nor blockedMap.
- R8: A pass-through read returns the count zero-extended. A pass-through write is ignored.
- R9: A control read returns E at bit 0, F at bit 1, T at bit 16 and the FIFO flag at bit 17. All other bits read zero. A control write loads T, E and F from those same bit positions and cannot change the FIFO flag.
- R10: After reset the count, the T, E and F bits and blockedMap are zero, and the FIFO flag equals FIFO_FLAG_INIT, which is 0 by default.
- R11: Nothing changes while reqValid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request in this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Access address; bits [6:3] give the view code |
| reqData | input | DATA_W | Store data |
| reqThread | input | THREAD_W | Index of the requesting thread |
| rspData | output | DATA_W | Load data for the current request |
| rspStall | output | 1 | Current request is blocked |
| blockedMap | output | NUM_THREADS | Bitmap of blocked threads |
| wakePulse | output | 1 | Blocked threads are released this cycle |
| wakeMask | output | NUM_THREADS | Threads released by this wake |

## Verification
Two functions can fall in one cycle: a signal that raises the count and the release of blocked threads. The bench provokes this by parking every thread on an empty count with blocking waits and then issuing one signal. In the signal cycle it expects wakePulse high and a wakeMask of all threads. After the edge it expects an empty bitmap and a pass-through read of 1, so the release has not eaten the increment. The same pairing is repeated with a single parked thread, where the signal goes through the blocking view.

// File: rtl/semCellPkg.sv
package semCellPkg;

  typedef enum logic [3:0] {
    VIEW_PASS  = 4'd0,
    VIEW_CTRL  = 4'd1,
    VIEW_PV_BL = 4'd4,
    VIEW_PV_NB = 4'd5
  } viewCode_e;

  typedef enum logic [1:0] {
    RD_COUNT,
    RD_TAG,
    RD_ZERO,
    RD_ONES
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   takeOne;   // wait on a non-zero count
    logic   giveOne;   // signal
    logic   parkReq;   // blocking wait on zero count
    logic   tagLoad;   // control-view store
    rdSel_e rdSel;
  } semStrobe_t;

  localparam int TAG_E_BIT    = 0;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_T_BIT    = 16;
  localparam int TAG_FIFO_BIT = 17;
  localparam int VIEW_LSB     = 3;
  localparam int VIEW_W       = 4;

endpackage

// File: rtl/semCellCtrl.sv
module semCellCtrl
  import semCellPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [3:0] viewCode,
  input  logic       fifoFlag,
  input  logic       countZero,
  output semStrobe_t strobe
);

  logic isPv;
  logic isBlocking;
  logic pvLive;

  always_comb begin
    isPv       = (viewCode == VIEW_PV_BL) || (viewCode == VIEW_PV_NB);
    isBlocking = (viewCode == VIEW_PV_BL);
    pvLive     = reqValid && isPv && !fifoFlag;

    strobe.takeOne = pvLive && !reqWrite && !countZero;
    strobe.parkReq = pvLive && !reqWrite && countZero && isBlocking;
    strobe.giveOne = pvLive && reqWrite;
    strobe.tagLoad = reqValid && reqWrite && (viewCode == VIEW_CTRL);

    unique case (viewCode)
      VIEW_PASS:  strobe.rdSel = RD_COUNT;
      VIEW_CTRL:  strobe.rdSel = RD_TAG;
      VIEW_PV_BL,
      VIEW_PV_NB: strobe.rdSel = fifoFlag ? RD_ZERO : RD_COUNT;
      default:    strobe.rdSel = RD_ONES;
    endcase
  end

  // R1
  // strobe_onehot_chk
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeOne, strobe.giveOne, strobe.parkReq, strobe.tagLoad}));

  // R7
  // fifo_gate_chk
  fifo_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlag |-> !(strobe.takeOne || strobe.giveOne || strobe.parkReq));

  // R11
  // idle_quiet_chk
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(strobe.takeOne || strobe.giveOne || strobe.parkReq || strobe.tagLoad));

endmodule

// File: rtl/semCellDatapath.sv
module semCellDatapath
  import semCellPkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int COUNT_W        = 16,
  parameter int NUM_THREADS    = 4,
  parameter int THREAD_W       = 2,
  parameter bit FIFO_FLAG_INIT = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  semStrobe_t             strobe,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [THREAD_W-1:0]    thread,
  output logic                   fifoFlag,
  output logic                   countZero,
  output logic [DATA_W-1:0]      rdData,
  output logic [NUM_THREADS-1:0] blockedMap,
  output logic                   wakePulse,
  output logic [NUM_THREADS-1:0] wakeMask
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0]     count;
  logic                   tagT, tagE, tagF;
  logic [NUM_THREADS-1:0] parkBit;
  logic [DATA_W-1:0]      tagWord;

  assign fifoFlag  = FIFO_FLAG_INIT;
  assign countZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.takeOne) begin
      count <= count - 1'b1;
    end else if (strobe.giveOne && count != COUNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagT <= 1'b0;
      tagE <= 1'b0;
      tagF <= 1'b0;
    end else if (strobe.tagLoad) begin
      tagT <= wrData[TAG_T_BIT];
      tagE <= wrData[TAG_E_BIT];
      tagF <= wrData[TAG_F_BIT];
    end
  end

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_park
      assign parkBit[t] = (thread == THREAD_W'(t));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockedMap <= '0;
    end else if (strobe.giveOne) begin
      blockedMap <= '0;
    end else if (strobe.parkReq) begin
      blockedMap <= blockedMap | parkBit;
    end
  end

  assign wakePulse = strobe.giveOne && (blockedMap != '0);
  assign wakeMask  = strobe.giveOne ? blockedMap : '0;

  always_comb begin
    tagWord               = '0;
    tagWord[TAG_E_BIT]    = tagE;
    tagWord[TAG_F_BIT]    = tagF;
    tagWord[TAG_T_BIT]    = tagT;
    tagWord[TAG_FIFO_BIT] = fifoFlag;
    unique case (strobe.rdSel)
      RD_COUNT: rdData = DATA_W'(count);
      RD_TAG:   rdData = tagWord;
      RD_ZERO:  rdData = '0;
      default:  rdData = '1;
    endcase
  end

  // R2 R5
  // count_step_chk
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |->
      (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

  // R5
  // no_overflow_chk
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.giveOne && count == COUNT_MAX) |=> count == COUNT_MAX);

  // R6
  // wake_clear_chk
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> blockedMap == '0);

  // R3
  // park_zero_chk
  park_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parkReq |=> count == '0);

endmodule

// File: rtl/semCountCell.sv
module semCountCell
  import semCellPkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int ADDR_W         = 8,
  parameter int COUNT_W        = 16,
  parameter int NUM_THREADS    = 4,
  parameter bit FIFO_FLAG_INIT = 1'b0,
  localparam int THREAD_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqData,
  input  logic [THREAD_W-1:0]    reqThread,
  output logic [DATA_W-1:0]      rspData,
  output logic                   rspStall,
  output logic [NUM_THREADS-1:0] blockedMap,
  output logic                   wakePulse,
  output logic [NUM_THREADS-1:0] wakeMask
);

  semStrobe_t strobe;
  logic       fifoFlag;
  logic       countZero;
  logic [3:0] viewCode;

  assign viewCode = reqAddr[VIEW_LSB +: VIEW_W];
  assign rspStall = strobe.parkReq;

  semCellCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .viewCode  (viewCode),
    .fifoFlag  (fifoFlag),
    .countZero (countZero),
    .strobe    (strobe)
  );

  semCellDatapath #(
    .DATA_W         (DATA_W),
    .COUNT_W        (COUNT_W),
    .NUM_THREADS    (NUM_THREADS),
    .THREAD_W       (THREAD_W),
    .FIFO_FLAG_INIT (FIFO_FLAG_INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (reqData),
    .thread     (reqThread),
    .fifoFlag   (fifoFlag),
    .countZero  (countZero),
    .rdData     (rspData),
    .blockedMap (blockedMap),
    .wakePulse  (wakePulse),
    .wakeMask   (wakeMask)
  );

  // R3
  // stall_cause_chk
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspStall |-> (!reqWrite && viewCode == VIEW_PV_BL && rspData == '0));

endmodule

// File: tb/semCountCell_tb.sv
module semCountCell_tb;

  localparam int DW = 64;
  localparam int CW = 4;
  localparam int NT = 4;
  localparam logic [DW-1:0] CMAX = (64'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [7:0]    reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [1:0]    reqThread = '0;
  logic [DW-1:0] rspData, fRspData;
  logic          rspStall, fRspStall;
  logic [NT-1:0] blockedMap, fBlockedMap;
  logic          wakePulse, fWakePulse;
  logic [NT-1:0] wakeMask, fWakeMask;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] sRd, sFRd;
  logic          sStall, sFStall, sWake;
  logic [NT-1:0] sMask;
  logic [DW-1:0] expCount;
  logic [NT-1:0] expMap;

  always #2.5 clk = ~clk;

  semCountCell #(.DATA_W(DW), .COUNT_W(CW), .NUM_THREADS(NT)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqThread(reqThread),
    .rspData(rspData), .rspStall(rspStall), .blockedMap(blockedMap),
    .wakePulse(wakePulse), .wakeMask(wakeMask)
  );

  semCountCell #(.DATA_W(DW), .COUNT_W(CW), .NUM_THREADS(NT), .FIFO_FLAG_INIT(1'b1)) u_fifoDut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqThread(reqThread),
    .rspData(fRspData), .rspStall(fRspStall), .blockedMap(fBlockedMap),
    .wakePulse(fWakePulse), .wakeMask(fWakeMask)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int view, input logic [DW-1:0] d, input int th);
    @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = w;
    reqAddr   = 8'(view << 3);
    reqData   = d;
    reqThread = 2'(th);
    #1;
    sRd = rspData; sStall = rspStall; sWake = wakePulse; sMask = wakeMask;
    sFRd = fRspData; sFStall = fRspStall;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  task automatic peekCount(output logic [DW-1:0] c);
    acc(1'b0, 0, '0, 0);
    c = sRd;
  endtask

  initial begin
    logic [DW-1:0] c;
    expCount = '0;
    expMap = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    check("R10 map", 64'(blockedMap), 64'd0);
    peekCount(c); check("R10 count", c, 64'd0);
    acc(1'b0, 1, '0, 0);
    check("R10 tag", sRd, 64'd0);
    check("R10 fifo tag", sFRd, 64'd1 << 17);

    // R11 inputs without valid
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 8'(4 << 3); reqData = '1;
    @(negedge clk);
    check("R11 no wake", 64'(wakePulse), 64'd0);
    @(posedge clk); #1;
    peekCount(c); check("R11 count", c, 64'd0);

    // R5 signal sweep up through saturation
    for (int i = 1; i <= int'(CMAX) + 3; i++) begin
      acc(1'b1, (i % 2) ? 4 : 5, 64'hDEAD_0000 + 64'(i), i % NT);
      if (expCount != CMAX) expCount = expCount + 1;
      check("R6 no wake", 64'(sWake), 64'd0);
      peekCount(c); check("R5 count", c, expCount);
    end
    acc(1'b0, 0, '0, 0);
    check("R7 fifo count", sFRd, 64'd0);

    // R2 waits from full down, R7 fifo reads zero
    while (expCount != 0) begin
      acc(1'b0, (expCount % 2 == 0) ? 4 : 5, '0, 1);
      check("R2 pre value", sRd, expCount);
      check("R2 no stall", 64'(sStall), 64'd0);
      check("R7 fifo read", sFRd, 64'd0);
      check("R7 fifo stall", 64'(sFStall), 64'd0);
      expCount = expCount - 1;
    end
    peekCount(c); check("R2 empty", c, 64'd0);

    // R4 non-blocking wait on zero
    for (int k = 0; k < 2; k++) begin
      acc(1'b0, 5, '0, k);
      check("R4 value", sRd, 64'd0);
      check("R4 stall", 64'(sStall), 64'd0);
      check("R4 map", 64'(blockedMap), 64'd0);
    end

    // R3 blocking waits park every thread
    for (int t = 0; t < NT; t++) begin
      acc(1'b0, 4, '0, t);
      expMap[t] = 1'b1;
      check("R3 stall", 64'(sStall), 64'd1);
      check("R3 value", sRd, 64'd0);
      check("R3 map", 64'(blockedMap), 64'(expMap));
      check("R7 fifo stall", 64'(sFStall), 64'd0);
    end
    acc(1'b0, 4, '0, 0);
    check("R3 map repeat", 64'(blockedMap), 64'(expMap));
    peekCount(c); check("R3 count", c, 64'd0);
    check("R7 fifo map", 64'(fBlockedMap), 64'd0);

    // R6 signal and release in one cycle
    acc(1'b1, 5, 64'h1234, 3);
    check("R6 wake", 64'(sWake), 64'd1);
    check("R6 mask", 64'(sMask), 64'hF);
    check("R6 map cleared", 64'(blockedMap), 64'd0);
    peekCount(c); check("R6 count", c, 64'd1);

    acc(1'b0, 5, '0, 0);
    acc(1'b0, 4, '0, 2);
    check("R3 single", 64'(blockedMap), 64'h4);
    acc(1'b1, 4, '0, 0);
    check("R6 mask single", 64'(sMask), 64'h4);
    check("R6 map single", 64'(blockedMap), 64'd0);
    peekCount(c); check("R6 count single", c, 64'd1);

    // R8 pass-through write ignored
    acc(1'b1, 0, 64'h7, 0);
    peekCount(c); check("R8 bypass write", c, 64'd1);

    // R1 undefined views
    for (int v = 2; v < 16; v++) begin
      if (v == 4 || v == 5) continue;
      acc(1'b0, v, '0, 0);
      check("R1 read ones", sRd, '1);
      acc(1'b1, v, '1, 0);
      peekCount(c); check("R1 write count", c, 64'd1);
      acc(1'b0, 1, '0, 0); check("R1 write tag", sRd, 64'd0);
    end

    // R9 control view layout
    acc(1'b1, 1, '1, 0);
    acc(1'b0, 1, '0, 0);
    check("R9 tag set", sRd, (64'd1 << 16) | 64'd3);
    check("R9 fifo tag", sFRd, (64'd1 << 17) | (64'd1 << 16) | 64'd3);
    acc(1'b1, 1, 64'h2, 0);
    acc(1'b0, 1, '0, 0);
    check("R9 tag partial", sRd, 64'd2);
    peekCount(c); check("R9 count kept", c, 64'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule